// File: doc/BRIEF.md
# Synchronous Serial Absolute Encoder Receiver

This block is the clock master on a synchronous serial link to a multi-turn absolute position encoder. A one-cycle start request begins a frame. The block then sends a burst of clock pulses and samples the encoder data line once per pulse. When the frame is complete, it checks odd parity and decodes the Gray-coded position. It then presents a multi-turn count, a single-turn count and a status bit, together with a one-cycle valid strobe.

After the last clock pulse, the block waits out a monoflop recovery window so that the encoder can return to its idle state. Start requests made during this window are ignored. A configuration input reverses the direction of the single-turn count. A second configuration input enables a line check: when it is enabled, a data line found low before a frame starts is reported as a fault, and no frame is read.

Top module: `ssi_enc_rx`

## Requirements
- R1: The clock output is high while idle. An accepted start sends exactly 29 low pulses: one for each of the 28 position-frame bits and one for the parity bit. Each pulse falls first, and the data line is sampled when the clock rises again. The clock then stays high.
- R2: Each clock half period lasts SYS_HZ/(2*SSI_HZ) system cycles. With the defaults of 50 MHz and 1 MHz, this is 25 cycles.
- R3: The first bit received is frame position 0. The multi-turn field is 13 bits wide, starts at position 0 and arrives most significant bit first. The single-turn field is 14 bits wide and starts at position 13. The status bit is at position 27, and the parity bit arrives last.
- R4: Each field is converted from Gray code to binary on its own. Bit i of the binary value is the XOR of Gray bits i and above within that field.
- R5: The 28 frame bits plus the parity bit must contain an odd number of ones. If they do not, parity_err_o pulses for one cycle, valid_o stays low, and all position outputs keep their previous values.
- R6: On a frame with correct parity, valid_o pulses for exactly one cycle. The multi-turn, single-turn and status outputs take their new values in that same cycle.
- R7: When cfg_reverse_i is 1, single_o is 16383 minus the decoded single-turn value. The multi-turn output is not affected by this setting.
- R8: After the last rising clock edge, start requests are ignored for MONO_NS (16 us), which is 800 cycles by default. The first request after that window is accepted.
- R9: When cfg_sigchk_i is 1 and the synchronized data line is low at a start request, line_err_o pulses for one cycle. In that case no clock pulse is sent and the outputs do not change. When cfg_sigchk_i is 0, a low line does not stop the frame.
- R10: A start request made during a clock burst is ignored. It neither lengthens the burst nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to read one frame |
| sdata_i | input | 1 | Serial data from the encoder |
| cfg_reverse_i | input | 1 | 1 = reversed single-turn counting |
| cfg_sigchk_i | input | 1 | 1 = check that the line is idle-high before a frame |
| sclk_o | output | 1 | Serial clock to the encoder |
| multi_o | output | 13 | Decoded multi-turn count |
| single_o | output | 14 | Decoded single-turn count |
| status_o | output | 1 | Status bit from the last good frame |
| valid_o | output | 1 | One-cycle strobe marking a new good position |
| parity_err_o | output | 1 | One-cycle strobe marking a parity failure |
| line_err_o | output | 1 | One-cycle strobe marking a data line found low before a frame |

## Verification
The end of a frame is the cycle in which the parity verdict and the update of the position outputs meet. A corrupted parity bit must therefore raise the error strobe in exactly the cycle where valid would have risen, and the outputs must stay frozen in that cycle. The bench provokes this by sending a good frame followed by one with its parity bit inverted. A scoreboard entry that carries the previous good values then judges the kind of event and the held outputs. A second pairing, a start request arriving during the burst or during the recovery window, is judged by counting falling clock edges.

// File: rtl/ssi_rx_pkg.sv
package ssi_rx_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_BURST = 2'd1,
      SEQ_MONO  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/ssi_rx_gray2bin.sv
module ssi_rx_gray2bin #(
   parameter int W = 8
) (
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   if (W < 1) begin : g_bad_w
      $error("ssi_rx_gray2bin: W must be at least 1");
   end

   // R4: each binary bit folds every Gray bit at or above it
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin_o[i] = ^gray_i[W-1:i];
   end
endmodule

// File: rtl/ssi_rx_seq.sv
module ssi_rx_seq
   import ssi_rx_pkg::*;
#(
   parameter int NBITS    = 29,
   parameter int HALF_CYC = 25,
   parameter int MONO_CYC = 800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             sdata_i,
   input  logic             sigchk_i,
   output logic             sclk_o,
   output logic [NBITS-1:0] frame_o,
   output logic             done_o,
   output logic             line_err_o
);
   localparam int HCW = $clog2(HALF_CYC);
   localparam int MCW = $clog2(MONO_CYC);
   localparam int BCW = $clog2(NBITS);
   localparam logic [HCW-1:0] H_LAST = HCW'(HALF_CYC - 1);
   localparam logic [MCW-1:0] M_LAST = MCW'(MONO_CYC - 1);
   localparam logic [BCW-1:0] B_LAST = BCW'(NBITS - 1);

   if (HALF_CYC < 2) begin : g_bad_half
      $error("ssi_rx_seq: HALF_CYC must be at least 2");
   end
   if (MONO_CYC < 2) begin : g_bad_mono
      $error("ssi_rx_seq: MONO_CYC must be at least 2");
   end
   if (NBITS < 2) begin : g_bad_nbits
      $error("ssi_rx_seq: NBITS must be at least 2");
   end

   seq_state_e     state;
   logic [HCW-1:0] hcnt;
   logic [MCW-1:0] mcnt;
   logic [BCW-1:0] bcnt;
   logic [1:0]     sync;
   logic           sd;

   assign sd = sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         sclk_o     <= 1'b1;
         hcnt       <= '0;
         mcnt       <= '0;
         bcnt       <= '0;
         frame_o    <= '0;
         done_o     <= 1'b0;
         line_err_o <= 1'b0;
         sync       <= 2'b11;
      end else begin
         done_o     <= 1'b0;
         line_err_o <= 1'b0;
         sync       <= {sync[0], sdata_i};
         unique case (state)
            SEQ_IDLE: begin
               if (start_i) begin
                  if (sigchk_i && !sd) begin
                     line_err_o <= 1'b1;
                  end else begin
                     state  <= SEQ_BURST;
                     sclk_o <= 1'b0;
                     hcnt   <= '0;
                     bcnt   <= '0;
                  end
               end
            end
            SEQ_BURST: begin
               if (hcnt == H_LAST) begin
                  hcnt <= '0;
                  if (!sclk_o) begin
                     sclk_o  <= 1'b1;
                     frame_o <= {frame_o[NBITS-2:0], sd};
                     if (bcnt == B_LAST) begin
                        state  <= SEQ_MONO;
                        mcnt   <= '0;
                        done_o <= 1'b1;
                     end else begin
                        bcnt <= bcnt + 1'b1;
                     end
                  end else begin
                     sclk_o <= 1'b0;
                  end
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            SEQ_MONO: begin
               if (mcnt == M_LAST) state <= SEQ_IDLE;
               else                mcnt  <= mcnt + 1'b1;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   p_clk_high_outside_burst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_BURST) |-> sclk_o);

   p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> ($past(hcnt) == H_LAST));

   p_mono_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_MONO && mcnt != M_LAST) |=> (state == SEQ_MONO && sclk_o));

   p_line_err_no_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_err_o |-> (state == SEQ_IDLE && sclk_o));

   p_burst_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_BURST && bcnt != B_LAST) |=> (state == SEQ_BURST));
endmodule

// File: rtl/ssi_rx_decode.sv
module ssi_rx_decode #(
   parameter int NBITS    = 29,
   parameter int MT_W     = 13,
   parameter int MT_POS   = 0,
   parameter int ST_W     = 14,
   parameter int ST_POS   = 13,
   parameter int STAT_POS = 27,
   parameter bit REV_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] frame_i,
   input  logic             done_i,
   input  logic             reverse_i,
   output logic [MT_W-1:0]  multi_o,
   output logic [ST_W-1:0]  single_o,
   output logic             status_o,
   output logic             valid_o,
   output logic             perr_o
);
   localparam int DATA_W = NBITS - 1;
   localparam int MT_HI  = NBITS - 1 - MT_POS;
   localparam int ST_HI  = NBITS - 1 - ST_POS;
   localparam int STAT_I = NBITS - 1 - STAT_POS;
   localparam logic [ST_W-1:0] ST_MAX = '1;

   if (MT_POS + MT_W > DATA_W) begin : g_bad_mt
      $error("ssi_rx_decode: multi-turn field exceeds frame");
   end
   if (ST_POS + ST_W > DATA_W) begin : g_bad_st
      $error("ssi_rx_decode: single-turn field exceeds frame");
   end
   if (STAT_POS >= DATA_W) begin : g_bad_stat
      $error("ssi_rx_decode: status position exceeds frame");
   end

   logic [MT_W-1:0] mt_bin;
   logic [ST_W-1:0] st_bin, st_dir;
   logic            par_ok;

   ssi_rx_gray2bin #(.W(MT_W)) u_mt_g2b (
      .gray_i (frame_i[MT_HI -: MT_W]),
      .bin_o  (mt_bin)
   );

   ssi_rx_gray2bin #(.W(ST_W)) u_st_g2b (
      .gray_i (frame_i[ST_HI -: ST_W]),
      .bin_o  (st_bin)
   );

   if (REV_EN) begin : g_rev
      assign st_dir = reverse_i ? (ST_MAX - st_bin) : st_bin;
   end else begin : g_fwd
      logic unused_rev;
      assign unused_rev = reverse_i;
      assign st_dir     = st_bin;
   end

   // odd parity over data plus parity bit
   assign par_ok = ^frame_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         multi_o  <= '0;
         single_o <= '0;
         status_o <= 1'b0;
         valid_o  <= 1'b0;
         perr_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         if (done_i) begin
            if (par_ok) begin
               multi_o  <= mt_bin;
               single_o <= st_dir;
               status_o <= frame_i[STAT_I];
               valid_o  <= 1'b1;
            end else begin
               perr_o <= 1'b1;
            end
         end
      end
   end

   p_perr_holds_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |-> ($stable(multi_o) && $stable(single_o) && $stable(status_o)));

   p_perr_excludes_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(perr_o && valid_o));

   p_valid_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   p_outputs_move_only_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(multi_o) && $stable(single_o) && $stable(status_o)));
endmodule

// File: rtl/ssi_enc_rx.sv
module ssi_enc_rx #(
   parameter int SYS_HZ   = 50_000_000,
   parameter int SSI_HZ   = 1_000_000,
   parameter int MONO_NS  = 16_000,
   parameter int FRAME_W  = 28,
   parameter int MT_W     = 13,
   parameter int MT_POS   = 0,
   parameter int ST_W     = 14,
   parameter int ST_POS   = 13,
   parameter int STAT_POS = 27,
   parameter bit REV_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            sdata_i,
   input  logic            cfg_reverse_i,
   input  logic            cfg_sigchk_i,
   output logic            sclk_o,
   output logic [MT_W-1:0] multi_o,
   output logic [ST_W-1:0] single_o,
   output logic            status_o,
   output logic            valid_o,
   output logic            parity_err_o,
   output logic            line_err_o
);
   localparam int NBITS    = FRAME_W + 1;
   localparam int HALF_CYC = SYS_HZ / (2 * SSI_HZ);
   localparam int MONO_CYC = (SYS_HZ / 1000) * MONO_NS / 1_000_000;

   if (SYS_HZ < 4 * SSI_HZ) begin : g_bad_rate
      $error("ssi_enc_rx: system clock must be at least 4x the serial clock");
   end

   logic [NBITS-1:0] frame;
   logic             done;

   ssi_rx_seq #(
      .NBITS    (NBITS),
      .HALF_CYC (HALF_CYC),
      .MONO_CYC (MONO_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .sdata_i    (sdata_i),
      .sigchk_i   (cfg_sigchk_i),
      .sclk_o     (sclk_o),
      .frame_o    (frame),
      .done_o     (done),
      .line_err_o (line_err_o)
   );

   ssi_rx_decode #(
      .NBITS    (NBITS),
      .MT_W     (MT_W),
      .MT_POS   (MT_POS),
      .ST_W     (ST_W),
      .ST_POS   (ST_POS),
      .STAT_POS (STAT_POS),
      .REV_EN   (REV_EN)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_i   (frame),
      .done_i    (done),
      .reverse_i (cfg_reverse_i),
      .multi_o   (multi_o),
      .single_o  (single_o),
      .status_o  (status_o),
      .valid_o   (valid_o),
      .perr_o    (parity_err_o)
   );

   p_no_double_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({valid_o, parity_err_o, line_err_o}));
endmodule

// File: tb/ssi_enc_rx_test.sv
module ssi_enc_rx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cfg_reverse_i = 1'b0;
   logic        cfg_sigchk_i = 1'b0;
   logic        enc_bit = 1'b1;
   logic        force_low = 1'b0;
   logic        sdata_i;
   logic        sclk_o;
   logic [12:0] multi_o;
   logic [13:0] single_o;
   logic        status_o, valid_o, parity_err_o, line_err_o;

   assign sdata_i = enc_bit & ~force_low;

   always #10 clk = ~clk;

   ssi_enc_rx uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdata_i(sdata_i),
      .cfg_reverse_i(cfg_reverse_i), .cfg_sigchk_i(cfg_sigchk_i),
      .sclk_o(sclk_o), .multi_o(multi_o), .single_o(single_o),
      .status_o(status_o), .valid_o(valid_o),
      .parity_err_o(parity_err_o), .line_err_o(line_err_o)
   );

   typedef struct {
      int kind;   // 0 good frame, 1 parity fault, 2 line fault
      int mt;
      int st;
      int stat;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   n_fall = 0;
   int   tx_base = 0;
   logic [28:0] tx_bits = '1;
   int   low_run = 0;
   int   last_low = 0;
   int   good_mt = 0, good_st = 0, good_stat = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // encoder model: new bit after each falling edge, idle-high after the frame
   always @(sclk_o) begin
      if (rst_n) begin
         if (sclk_o == 1'b0) begin
            if (n_fall - tx_base >= 0 && n_fall - tx_base < 29)
               enc_bit = tx_bits[28 - (n_fall - tx_base)];
            n_fall = n_fall + 1;
         end else if (n_fall - tx_base >= 29) begin
            enc_bit = 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      if (!sclk_o) low_run <= low_run + 1;
      else if (low_run != 0) begin
         last_low <= low_run;
         low_run  <= 0;
      end
   end

   // monitor: pops one expectation per event strobe
   always @(negedge clk) begin
      if (rst_n && (valid_o || parity_err_o || line_err_o)) begin
         int got;
         got = valid_o ? 0 : (parity_err_o ? 1 : 2);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected event", got, -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(got == e.kind, "R5/R6/R9 event kind", got, e.kind);
            chk(int'(multi_o) == e.mt, "R3/R4 multi-turn", int'(multi_o), e.mt);
            chk(int'(single_o) == e.st, "R3/R4/R7 single-turn", int'(single_o), e.st);
            chk(int'(status_o) == e.stat, "R3 status bit", int'(status_o), e.stat);
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   // mode: 0 plain, 1 start mid-burst (R10), 2 start inside monoflop (R8)
   task automatic send_frame(input int mt, input int st, input int stat,
                             input bit rev, input bit badpar, input int mode);
      logic [12:0] gm;
      logic [13:0] gs;
      logic [27:0] data;
      logic        par;
      exp_t        e;
      int          f0;
      gm   = 13'(mt) ^ (13'(mt) >> 1);
      gs   = 14'(st) ^ (14'(st) >> 1);
      data = {gm, gs, 1'(stat)};
      par  = ~(^data);
      if (badpar) par = ~par;
      cfg_reverse_i = rev;
      if (badpar) begin
         e = '{1, good_mt, good_st, good_stat};
      end else begin
         good_mt   = mt;
         good_st   = rev ? (16383 - st) : st;
         good_stat = stat;
         e = '{0, good_mt, good_st, good_stat};
      end
      exp_q.push_back(e);
      tx_bits = {data, par};
      tx_base = n_fall;
      f0      = n_fall;
      pulse_start();
      if (mode == 1) begin
         wait (n_fall - f0 >= 10);
         pulse_start();
      end
      wait (n_fall - f0 >= 29 && sclk_o == 1'b1);
      if (mode == 2) begin
         repeat (10) @(negedge clk);
         pulse_start();
         repeat (700) @(negedge clk);
         chk(n_fall - f0 == 29, "R8 start in monoflop ignored", n_fall - f0, 29);
         repeat (120) @(negedge clk);
      end else begin
         repeat (830) @(negedge clk);
      end
      chk(n_fall - f0 == 29, "R1/R10 clock pulses per frame", n_fall - f0, 29);
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int f0;
      repeat (4) @(negedge clk);
      chk(sclk_o == 1'b1, "R1 clock high in reset", int'(sclk_o), 1);
      chk(valid_o == 1'b0, "R6 no valid in reset", int'(valid_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sclk_o == 1'b1, "R1 clock idle high", int'(sclk_o), 1);
      chk(multi_o == '0 && single_o == '0, "R6 outputs zero after reset",
          int'(multi_o) + int'(single_o), 0);

      send_frame(13'h1234, 14'h2abc, 1, 1'b0, 1'b0, 0);
      chk(last_low == 25, "R2 half period cycles", last_low, 25);
      send_frame(0, 0, 0, 1'b0, 1'b0, 0);
      send_frame(8191, 16383, 0, 1'b0, 1'b0, 0);
      send_frame(13'h0aaa, 14'h1555, 1, 1'b0, 1'b0, 0);
      send_frame(1, 1, 0, 1'b0, 1'b0, 0);
      // R7 reversed counting
      send_frame(77, 100, 0, 1'b1, 1'b0, 0);
      send_frame(4096, 0, 1, 1'b1, 1'b0, 0);
      // R5 parity failure holds the previous values
      send_frame(500, 600, 0, 1'b0, 1'b0, 0);
      send_frame(1, 2, 1, 1'b0, 1'b1, 0);
      // R10 start during burst; R8 start during monoflop, then accepted after
      send_frame(321, 9999, 1, 1'b0, 1'b0, 1);
      send_frame(222, 3333, 0, 1'b0, 1'b0, 2);
      send_frame(4000, 12000, 1, 1'b0, 1'b0, 0);

      // R9 line check enabled with the line low: fault, no burst
      cfg_sigchk_i = 1'b1;
      force_low    = 1'b1;
      repeat (5) @(negedge clk);
      exp_q.push_back('{2, good_mt, good_st, good_stat});
      f0 = n_fall;
      pulse_start();
      repeat (100) @(negedge clk);
      chk(n_fall == f0, "R9 no clock after line fault", n_fall - f0, 0);
      chk(sclk_o == 1'b1, "R9 clock stays high", int'(sclk_o), 1);
      force_low = 1'b0;
      repeat (5) @(negedge clk);
      send_frame(99, 88, 1, 1'b0, 1'b0, 0);

      // R9 line check disabled: a low line does not stop the frame
      cfg_sigchk_i = 1'b0;
      force_low    = 1'b1;
      repeat (5) @(negedge clk);
      fork
         begin
            repeat (12) @(negedge clk);
            force_low = 1'b0;
         end
         send_frame(1000, 2000, 0, 1'b0, 1'b0, 0);
      join

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all expected events seen", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule